// File: doc/BRIEF.md
# Paced-Interrupt UART Register Front End

This block is the byte-wide register side of a classic 8250-compatible UART. Software sees eight byte registers behind a 3-bit offset, accessed with single-cycle read and write strobes. Received bytes come in on a valid/ready byte stream and are held in a one-byte holding register. Each byte written to the data register leaves on a one-cycle transmit strobe. The transmitter is treated as always ready. No bit timing, baud generation, FIFO or modem pin is modelled. The divisor latch bytes can be stored and read back, but nothing uses them.

Interrupts are paced. A receive or transmit interrupt is not raised at the moment its cause appears. It is raised when a per-source delay timer of `DELAY` clock cycles expires. The single level output `irq` goes high on expiry, and only when the matching enable bit in the interrupt-enable register is still set. There is one exception: if the transmit enable is written while the previous transmit interrupt lies more than `DELAY` cycles in the past, the transmit interrupt fires at once. Receive always takes priority over transmit when the identification register is read.

Stream rules: `rx_ready` is high whenever the holding register is empty, or while a data-register read is emptying it in the same cycle. A byte transfers on a clock edge where `rx_valid` and `rx_ready` are both high. While `rx_ready` is low, the source must hold `rx_valid` and `rx_data` stable. There is no back-pressure on the transmit side.

Top module: `uart_regs_pacer`

## Requirements
- R1: Bit 7 of the line-control register (offset 3) selects the divisor latch. While that bit is set, offsets 0 and 1 read and write the divisor low and high bytes, and no byte is transmitted. While it is clear, offsets 0 and 1 are the data register and the interrupt-enable register. Offset 3 and the modem-control register at offset 4 read back the last value written to them.
- R2: A data-register read returns the held byte, or 0x00 when nothing is held, and always drops `irq`. `rx_ready` is high when the holder is empty, or when a data read is emptying it. A held byte is never lost or changed until it is read.
- R3: A data-register write produces `tx_strobe` for exactly one cycle after the write edge, carrying the written byte on `tx_byte`, and drops `irq`. If the interrupt-enable register has bit 1 (transmit enable) set, the write also starts the transmit delay.
- R4: A started delay raises its status bit and `irq` exactly `DELAY` clock edges after the edge that started it. Starting a delay that is already running restarts it from `DELAY`.
- R5: A delay that expires while its enable bit is clear raises neither `irq` nor its status bit. Stimulus that would start a delay while its enable bit is clear starts nothing.
- R6: Writing the interrupt-enable register with bit 1 set fires the transmit interrupt on that edge if more than `DELAY` cycles have passed since the last transmit interrupt, with reset counting as such an event. Otherwise the write starts the transmit delay. Writing it with bit 1 clear cancels a pending transmit delay and drops `irq`.
- R7: Writing the interrupt-enable register with bit 0 (receive enable) set starts the receive delay when a byte is held. With bit 0 clear, the write cancels a pending receive delay and drops `irq`. With receive enabled, a byte arriving into the empty holder starts the receive delay. A data read that takes in a further byte in the same cycle restarts the receive delay.
- R8: A read of offset 2 returns 0x04 when the receive status is set. Otherwise it returns 0x02 when the transmit status is set, and that read clears the transmit status. Otherwise it returns 0x01. The receive status clears when a data read leaves the holder empty.
- R9: Offset 5 reads 0x60 when nothing is held and 0x61 when a byte is held. Bit 0 is data ready; bits 5 and 6 are the empty flags.
- R10: Offsets 6 and 7 always read 0x00. Writes to offsets 2 and 7 change no register and no output.
- R11: When an interrupt fires in the same cycle as an access that drops `irq`, `irq` is high after that edge.
- R12: After reset, all registers and status bits are zero, no delay runs, `irq` and `tx_strobe` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holder can accept a byte this cycle |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Transmitted byte, valid with tx_strobe |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can land on the same edge: a receive delay expiring and a data-register write that drops `irq`. The bench pushes a byte with receive interrupts enabled and counts `DELAY` edges from the handshake edge. It then times a data write to land exactly on the expiry edge. It requires `irq` to be high after that edge and the byte to leave on the transmit strobe. A second overlap is a data read that empties the holder while the next byte is accepted in the same edge. The bench judges this by the returned byte, by the restarted delay timing, and by the identification code.

// File: rtl/uart_pacer_pkg.sv
package uart_pacer_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_TXE  = 8'h02;
  localparam logic [7:0] ID_RXD  = 8'h04;
  localparam logic [7:0] LS_IDLE = 8'h60;

  localparam int EN_RX   = 0;
  localparam int EN_TX   = 1;
  localparam int LC_DIV  = 7;

  typedef struct packed {
    logic rd_data;
    logic wr_data;
    logic wr_ier;
    logic rd_iir;
  } acc_t;
endpackage

// File: rtl/uart_pace_timer.sv
module uart_pace_timer #(
  parameter int DELAY = 28,
  localparam int CW = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic expire,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= CW'(DELAY);
    else if (cancel)         cnt <= '0;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1)) && !start && !cancel;
  assign busy   = (cnt != '0);

  // R4
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == CW'(DELAY)));

  // R4
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          pop,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          arrive,
  output logic          more
);
  logic take;

  assign rx_ready = !full || pop;
  assign take     = rx_valid && rx_ready;
  assign arrive   = take && !full;
  assign more     = take && full && pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) begin
        full <= 1'b1;
        data <= rx_data;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(data)));
endmodule

// File: rtl/uart_tx_recency.sv
module uart_tx_recency #(
  parameter int DELAY = 28,
  localparam int CW = $clog2(DELAY + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fired,
  output logic long_ago
);
  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n || fired)            age <= '0;
    else if (age != CW'(DELAY + 1)) age <= age + 1'b1;
  end

  assign long_ago = (age > CW'(DELAY));

  // R6
  recency_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> !long_ago);
endmodule

// File: rtl/uart_regs_pacer.sv
module uart_regs_pacer
  import uart_pacer_pkg::*;
#(
  parameter int DELAY = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_strobe,
  output logic [7:0] tx_byte,
  output logic       irq
);
  logic [7:0] ier, lcr, mcr, div_lo, div_hi;
  logic       rx_st, tx_st;
  logic       div_sel;
  acc_t       acc;

  logic       hold_full, hold_arrive, hold_more;
  logic [7:0] hold_data;
  logic       rx_start, rx_cancel, rx_exp, rx_busy, rx_fire;
  logic       tx_start, tx_cancel, tx_exp, tx_busy, tx_fire, tx_now;
  logic       tx_long_ago, irq_drop;

  assign div_sel     = lcr[LC_DIV];
  assign acc.rd_data = bus_rd && (bus_addr == OFS_DATA) && !div_sel;
  assign acc.wr_data = bus_wr && (bus_addr == OFS_DATA) && !div_sel;
  assign acc.wr_ier  = bus_wr && (bus_addr == OFS_IER)  && !div_sel;
  assign acc.rd_iir  = bus_rd && (bus_addr == OFS_IIR);

  uart_rx_hold #(.DW(8)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .pop(acc.rd_data && hold_full),
    .full(hold_full), .data(hold_data),
    .arrive(hold_arrive), .more(hold_more)
  );

  assign rx_start  = (acc.rd_data && hold_more && ier[EN_RX])
                   || (acc.wr_ier && bus_wdata[EN_RX] && hold_full)
                   || (hold_arrive && ier[EN_RX]);
  assign rx_cancel = acc.wr_ier && !bus_wdata[EN_RX];

  assign tx_now    = acc.wr_ier && bus_wdata[EN_TX] && tx_long_ago;
  assign tx_start  = (acc.wr_data && ier[EN_TX])
                   || (acc.wr_ier && bus_wdata[EN_TX] && !tx_long_ago);
  assign tx_cancel = acc.wr_ier && !bus_wdata[EN_TX];

  uart_pace_timer #(.DELAY(DELAY)) u_rx_tmr (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .cancel(rx_cancel),
    .expire(rx_exp), .busy(rx_busy)
  );

  uart_pace_timer #(.DELAY(DELAY)) u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .cancel(tx_cancel),
    .expire(tx_exp), .busy(tx_busy)
  );

  assign rx_fire = rx_exp && ier[EN_RX];
  assign tx_fire = (tx_exp && ier[EN_TX]) || tx_now;

  uart_tx_recency #(.DELAY(DELAY)) u_recency (
    .clk(clk), .rst_n(rst_n), .fired(tx_fire), .long_ago(tx_long_ago)
  );

  assign irq_drop = acc.rd_data || acc.wr_data
                  || (acc.wr_ier && (!bus_wdata[EN_RX] || !bus_wdata[EN_TX]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier <= '0; lcr <= '0; mcr <= '0; div_lo <= '0; div_hi <= '0;
      rx_st <= 1'b0; tx_st <= 1'b0; irq <= 1'b0;
      tx_strobe <= 1'b0; tx_byte <= '0;
    end else begin
      irq <= (irq && !irq_drop) || rx_fire || tx_fire;

      if (rx_fire) rx_st <= 1'b1;
      else if (acc.rd_data && hold_full && !hold_more) rx_st <= 1'b0;

      if (tx_fire) tx_st <= 1'b1;
      else if (acc.rd_iir && !rx_st) tx_st <= 1'b0;

      tx_strobe <= acc.wr_data;
      if (acc.wr_data) tx_byte <= bus_wdata;

      if (bus_wr) begin
        unique case (bus_addr)
          OFS_DATA: if (div_sel) div_lo <= bus_wdata;
          OFS_IER:  if (div_sel) div_hi <= bus_wdata; else ier <= bus_wdata;
          OFS_LCR:  lcr <= bus_wdata;
          OFS_MCR:  mcr <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = div_sel ? div_lo : (hold_full ? hold_data : 8'h00);
        OFS_IER:  bus_rdata = div_sel ? div_hi : ier;
        OFS_IIR:  bus_rdata = rx_st ? ID_RXD : (tx_st ? ID_TXE : ID_NONE);
        OFS_LCR:  bus_rdata = lcr;
        OFS_MCR:  bus_rdata = mcr;
        OFS_LSR:  bus_rdata = LS_IDLE | {7'b0, hold_full};
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  // R3
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(bus_wr && (bus_addr == OFS_DATA)));

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rx_st || tx_st));

  // R8
  iir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_iir && !rx_st && tx_st && !tx_fire) |=> !tx_st);

  // R1
  div_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && div_sel) |=> !tx_strobe);
endmodule

// File: tb/tb_uart_regs_pacer.sv
module tb_uart_regs_pacer;
  localparam int DLY = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_strobe, irq;
  logic [7:0] tx_byte;

  int tests = 0, fails = 0;
  bit tb_div = 1'b0;
  bit done = 1'b0;
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];

  always #4 clk = ~clk;

  uart_regs_pacer #(.DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n && bus_rd) begin
      if (rd_exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2 unexpected read actual=%02h expected=none", bus_rdata);
      end else begin
        automatic logic [7:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
    if (rst_n && tx_strobe) begin
      if (tx_exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3 unexpected strobe actual=%02h expected=none", tx_byte);
      end else begin
        automatic logic [7:0] e = tx_exp_q.pop_front();
        chk("R3 tx byte", tx_byte, e);
      end
    end
  end

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 3'd0 && !tb_div) tx_exp_q.push_back(d);
    @(posedge clk);
    if (a == 3'd3) tb_div = d[7];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    chk("R2 ready when empty", {7'b0, rx_ready}, 8'h01);
    rx_data = b; rx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq", {7'b0, irq}, 8'h00);
    chk("R12 tx_strobe", {7'b0, tx_strobe}, 8'h00);
    chk("R12 rx_ready", {7'b0, rx_ready}, 8'h01);
    brd(3'd1, 8'h00, "R12 ier");
    brd(3'd3, 8'h00, "R12 lcr");
    brd(3'd2, 8'h01, "R12 iir");
    brd(3'd5, 8'h60, "R9 lsr empty");

    // R1 divisor routing
    bwr(3'd3, 8'h83);
    bwr(3'd0, 8'h34);
    bwr(3'd1, 8'h12);
    brd(3'd0, 8'h34, "R1 div lo");
    brd(3'd1, 8'h12, "R1 div hi");
    brd(3'd3, 8'h83, "R1 lcr");
    bwr(3'd3, 8'h03);
    brd(3'd1, 8'h00, "R1 ier untouched");
    bwr(3'd4, 8'h0B);
    brd(3'd4, 8'h0B, "R1 mcr");

    // R10 dead offsets
    bwr(3'd7, 8'h55);
    bwr(3'd2, 8'hFF);
    brd(3'd7, 8'h00, "R10 scratch");
    brd(3'd6, 8'h00, "R10 msr");
    brd(3'd2, 8'h01, "R10 iir after fcr write");
    brd(3'd3, 8'h03, "R10 lcr after fcr write");

    // R3/R5 transmit with enable clear: no interrupt
    bwr(3'd0, 8'hA5);
    idle(40);
    chk("R5 no irq when disabled", {7'b0, irq}, 8'h00);

    // R6 immediate transmit interrupt
    bwr(3'd1, 8'h02);
    chk("R6 immediate irq", {7'b0, irq}, 8'h01);
    brd(3'd2, 8'h02, "R8 iir tx");
    brd(3'd2, 8'h01, "R8 tx cleared by iir");
    chk("R8 iir keeps irq", {7'b0, irq}, 8'h01);
    bwr(3'd0, 8'h11);
    chk("R3 write drops irq", {7'b0, irq}, 8'h00);
    idle(DLY - 1);
    chk("R4 before expiry", {7'b0, irq}, 8'h00);
    idle(1);
    chk("R4 at expiry", {7'b0, irq}, 8'h01);

    // R6 recent interrupt -> delayed
    brd(3'd2, 8'h02, "R8 iir tx again");
    bwr(3'd1, 8'h00);
    chk("R6 disable drops irq", {7'b0, irq}, 8'h00);
    bwr(3'd1, 8'h02);
    chk("R6 delayed not immediate", {7'b0, irq}, 8'h00);
    idle(DLY - 1);
    chk("R6 delayed before", {7'b0, irq}, 8'h00);
    idle(1);
    chk("R6 delayed fires", {7'b0, irq}, 8'h01);
    brd(3'd2, 8'h02, "R8 iir delayed tx");
    bwr(3'd0, 8'h22);
    bwr(3'd1, 8'h00);
    idle(2 * DLY);
    chk("R6 cancel", {7'b0, irq}, 8'h00);
    brd(3'd2, 8'h01, "R6 cancel iir");

    // R7 receive path
    bwr(3'd1, 8'h01);
    push(8'h5A);
    chk("R7 no irq yet", {7'b0, irq}, 8'h00);
    brd(3'd5, 8'h61, "R9 lsr ready");
    rx_data = 8'h6B; rx_valid = 1'b1;
    chk("R2 back-pressure", {7'b0, rx_ready}, 8'h00);
    idle(DLY - 2);
    chk("R7 arrive before expiry", {7'b0, irq}, 8'h00);
    idle(1);
    chk("R7 arrive expiry", {7'b0, irq}, 8'h01);
    brd(3'd2, 8'h04, "R8 iir rx");
    brd(3'd0, 8'h5A, "R2 first byte");
    rx_valid = 1'b0;
    chk("R2 read drops irq", {7'b0, irq}, 8'h00);
    brd(3'd2, 8'h04, "R8 rx status kept while data held");
    idle(DLY - 2);
    chk("R7 restart before", {7'b0, irq}, 8'h00);
    idle(1);
    chk("R7 restart fires", {7'b0, irq}, 8'h01);
    brd(3'd0, 8'h6B, "R2 second byte");
    chk("R2 irq dropped", {7'b0, irq}, 8'h00);
    brd(3'd2, 8'h01, "R8 rx status cleared");
    brd(3'd0, 8'h00, "R2 empty read");
    brd(3'd5, 8'h60, "R9 lsr empty again");

    // R11 expiry and clearing write on the same edge
    push(8'h3C);
    idle(DLY - 1);
    bwr(3'd0, 8'h99);
    chk("R11 set beats clear", {7'b0, irq}, 8'h01);
    brd(3'd0, 8'h3C, "R11 byte");
    chk("R11 read clears", {7'b0, irq}, 8'h00);
    brd(3'd2, 8'h01, "R11 iir none");

    // R8 priority
    bwr(3'd1, 8'h00);
    push(8'h77);
    idle(DLY + 3);
    bwr(3'd1, 8'h03);
    chk("R6 immediate with both", {7'b0, irq}, 8'h01);
    idle(DLY);
    brd(3'd2, 8'h04, "R8 rx priority");
    brd(3'd2, 8'h04, "R8 rx priority kept");
    brd(3'd0, 8'h77, "R2 byte");
    brd(3'd2, 8'h02, "R8 tx not cleared under rx");
    brd(3'd2, 8'h01, "R8 none");

    idle(3);
    chk("R3 all tx seen", 8'(tx_exp_q.size()), 8'h00);
    chk("R2 all reads seen", 8'(rd_exp_q.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule